// File: doc/BRIEF.md
# Interleaved Round-Robin Multiply-Add Array

This block gets one result per clock out of a compute function that needs several clock cycles to settle. It does this without cutting the function into register stages. It holds several identical copies of the function side by side. A rotating dispatch pointer hands each accepted operand set to the next copy in turn. That copy latches the operands and keeps them steady while its logic settles over a multicycle path. A collector follows the same rotation, delayed by the settling time, and registers each finished result onto a single output in the order the operands arrived.

The arithmetic in each copy is an unsigned multiply-add, `a*b + c`. It stands in for whatever slow function a real design would put there. The number of copies is `NUM_UNITS`, and it also sets the settling time in clock cycles. The default is 4. Operands are 8 bits wide and results are 16 bits wide. The input and output each carry a valid flag. There is no back-pressure.

Top module: `ilv_array`

## Requirements
- R1: After synchronous reset (`rst` high at a rising edge), `out_valid` is low. It stays low until the first accepted operand set has completed.
- R2: Each result equals the unsigned value `in_a*in_b + in_c` of the operand set it belongs to. The result is 16 bits wide, so the largest value, 255*255+255 = 65280, is never truncated.
- R3: An operand set presented with `in_valid` high in clock cycle t appears on `out_res`, with `out_valid` high, in cycle t+NUM_UNITS exactly.
- R4: With `in_valid` held high on consecutive cycles, one result is delivered on every cycle. Results leave in the same order the operands arrived.
- R5: `out_valid` is high in cycle t+NUM_UNITS only when an operand set was accepted in cycle t. Gaps in the input reappear as gaps in the output.
- R6: In a cycle where `in_valid` is low, the operand inputs and the rotation are ignored. Garbage on `in_a`, `in_b` and `in_c` during such cycles changes neither `out_valid` nor any later result.
- R7: Reset asserted while results are in flight discards them. No result of an operand set accepted before the reset ever appears on the output. Operand sets accepted after the reset are processed normally.
- R8: Each unit keeps its latched operands unchanged for the whole NUM_UNITS-cycle computation. It is never reloaded while still computing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set on `in_a`/`in_b`/`in_c` is valid this cycle |
| in_a | input | 8 | Multiplicand |
| in_b | input | 8 | Multiplier |
| in_c | input | 8 | Addend |
| out_valid | output | 1 | `out_res` carries a finished result this cycle |
| out_res | output | 16 | Result `a*b + c` |

## Verification
The hardest situation to reach from the ports is a unit being revisited as early as possible. This happens when a long unbroken run of valid inputs brings the rotation back to a unit in the very cycle its countdown expires. The bench reaches it with a long back-to-back sweep of operand pairs, which includes the largest operands. It also drives a gapped stream with garbage operands in the idle cycles, so the pointer must hold while the output tracks every gap. The last case is a reset dropped in the middle of a full pipeline: it checks that none of the discarded results leaks out and that the rotation restarts cleanly.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int OP_W  = 8;
    localparam int RES_W = 2 * OP_W;

    typedef struct packed {
        logic [OP_W-1:0] a;
        logic [OP_W-1:0] b;
        logic [OP_W-1:0] c;
    } operand_t;

    function automatic logic [RES_W-1:0] mul_add(input operand_t op);
        return RES_W'(op.a) * RES_W'(op.b) + RES_W'(op.c);
    endfunction

endpackage

// File: rtl/ilv_dispatch.sv
module ilv_dispatch #(
    parameter int NUM_UNITS = 4,
    localparam int SEL_W = $clog2(NUM_UNITS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic [SEL_W-1:0]     sel,
    output logic [NUM_UNITS-1:0] load
);

    logic [SEL_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (in_valid) begin
            if (ptr == SEL_W'(NUM_UNITS - 1)) ptr <= '0;
            else                              ptr <= ptr + 1'b1;
        end
    end

    always_comb begin
        load = '0;
        if (in_valid) load[ptr] = 1'b1;
    end

    assign sel = ptr;

    AST_IDLE_HOLDS_PTR: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(ptr)); // R6

endmodule

// File: rtl/ilv_unit.sv
module ilv_unit
    import ilv_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    localparam int CNT_W = $clog2(NUM_UNITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  operand_t         op_in,
    output logic [RES_W-1:0] result,
    output logic             last
);

    operand_t         held;
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (load) held <= op_in;
    end

    always_ff @(posedge clk) begin
        if (rst)               remain <= '0;
        else if (load)         remain <= CNT_W'(NUM_UNITS - 1);
        else if (remain != '0) remain <= remain - 1'b1;
    end

    // Multicycle path: the held operands stay fixed while the countdown runs.
    assign result = mul_add(held);
    assign last   = (remain == CNT_W'(1));

    AST_NO_BUSY_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |-> (remain == '0)); // R8

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (remain != '0 && !load) |=> $stable(held)); // R8

endmodule

// File: rtl/ilv_collect.sv
module ilv_collect
    import ilv_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    localparam int SEL_W = $clog2(NUM_UNITS),
    localparam int DEPTH = NUM_UNITS - 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic [SEL_W-1:0]                in_sel,
    input  logic [NUM_UNITS-1:0][RES_W-1:0] unit_res,
    input  logic [NUM_UNITS-1:0]            unit_last,
    output logic                            out_valid,
    output logic [RES_W-1:0]                out_res
);

    logic [DEPTH-1:0]            stg_v;
    logic [DEPTH-1:0][SEL_W-1:0] stg_sel;

    always_ff @(posedge clk) begin
        if (rst) stg_v[0] <= 1'b0;
        else     stg_v[0] <= in_valid;
        stg_sel[0] <= in_sel;
    end

    for (genvar k = 1; k < DEPTH; k++) begin : g_delay
        always_ff @(posedge clk) begin
            if (rst) stg_v[k] <= 1'b0;
            else     stg_v[k] <= stg_v[k-1];
            stg_sel[k] <= stg_sel[k-1];
        end
    end

    logic             tail_v;
    logic [SEL_W-1:0] tail_sel;
    assign tail_v   = stg_v[DEPTH-1];
    assign tail_sel = stg_sel[DEPTH-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= tail_v;
            if (tail_v) out_res <= unit_res[tail_sel];
        end
    end

    AST_CAPTURE_DONE: assert property (@(posedge clk) disable iff (rst)
        tail_v |-> unit_last[tail_sel]); // R3

endmodule

// File: rtl/ilv_array.sv
module ilv_array
    import ilv_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    localparam int SEL_W = $clog2(NUM_UNITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  in_a,
    input  logic [OP_W-1:0]  in_b,
    input  logic [OP_W-1:0]  in_c,
    output logic             out_valid,
    output logic [RES_W-1:0] out_res
);

    operand_t                      op;
    logic [SEL_W-1:0]              sel;
    logic [NUM_UNITS-1:0]          load;
    logic [NUM_UNITS-1:0][RES_W-1:0] unit_res;
    logic [NUM_UNITS-1:0]          unit_last;

    assign op = '{a: in_a, b: in_b, c: in_c};

    ilv_dispatch #(.NUM_UNITS(NUM_UNITS)) i_dispatch (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .sel      (sel),
        .load     (load)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        ilv_unit #(.NUM_UNITS(NUM_UNITS)) i_unit (
            .clk    (clk),
            .rst    (rst),
            .load   (load[u]),
            .op_in  (op),
            .result (unit_res[u]),
            .last   (unit_last[u])
        );
    end

    ilv_collect #(.NUM_UNITS(NUM_UNITS)) i_collect (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sel    (sel),
        .unit_res  (unit_res),
        .unit_last (unit_last),
        .out_valid (out_valid),
        .out_res   (out_res)
    );

    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load)); // R4

    AST_LAST_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(unit_last)); // R4

endmodule

// File: tb/test_ilv_array.sv
module test_ilv_array;

    localparam int N      = 4;
    localparam int MAXCYC = 8192;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_a = '0, in_b = '0, in_c = '0;
    logic        out_valid;
    logic [15:0] out_res;

    always #5 clk = ~clk;

    ilv_array #(.NUM_UNITS(N)) i_ilv_array (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .out_valid(out_valid), .out_res(out_res)
    );

    int          total = 0;
    int          bad   = 0;
    int          cyc   = 0;
    bit          done  = 1'b0;
    string       req   = "R1";
    bit          exp_v [MAXCYC];
    logic [15:0] exp_d [MAXCYC];
    logic [15:0] rng   = 16'hACE1;

    task automatic check_now();
        total++;
        if (out_valid !== exp_v[cyc]) begin
            bad++;
            $display("FAIL %s cycle %0d out_valid=%0b expected %0b", req, cyc, out_valid, exp_v[cyc]);
        end else if (exp_v[cyc]) begin
            total++;
            if (out_res !== exp_d[cyc]) begin
                bad++;
                $display("FAIL %s cycle %0d out_res=%0d expected %0d", req, cyc, out_res, exp_d[cyc]);
            end
        end
    endtask

    // One clock: sample outputs at the falling edge, then drive the next inputs.
    task automatic step(input bit v, input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input bit r);
        @(negedge clk);
        check_now();
        rst = r; in_valid = v; in_a = a; in_b = b; in_c = c;
        if (r) begin
            for (int j = cyc + 1; j < MAXCYC; j++) exp_v[j] = 1'b0;
        end else if (v && cyc + N < MAXCYC) begin
            exp_v[cyc + N] = 1'b1;
            exp_d[cyc + N] = 16'(a) * 16'(b) + 16'(c);
        end
        cyc++;
    endtask

    task automatic next_rng();
        rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
    endtask

    initial begin
        for (int j = 0; j < MAXCYC; j++) begin exp_v[j] = 1'b0; exp_d[j] = '0; end
        // R1: reset, then idle and first inputs; out_valid low until first result
        req = "R1";
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        step(1, 8'd3, 8'd5, 8'd7, 0);
        // R3: isolated input, result exactly N cycles later and not before
        req = "R3";
        for (int k = 0; k < 2 * N; k++) step(0, 0, 0, 0, 0);
        step(1, 8'd255, 8'd255, 8'd255, 0);
        for (int k = 0; k < 2 * N; k++) step(0, 0, 0, 0, 0);
        // R2 R4 R8: long back-to-back sweep of operand pairs, incl. extremes
        req = "R2 R4 R8";
        for (int a = 0; a < 256; a += 5)
            for (int b = 0; b < 256; b += 7)
                step(1, 8'(a), 8'(b), 8'(a ^ b), 0);
        step(1, 8'd255, 8'd255, 8'd255, 0);
        step(1, 8'd0, 8'd0, 8'd0, 0);
        step(1, 8'd255, 8'd0, 8'd255, 0);
        step(1, 8'd1, 8'd255, 8'd0, 0);
        for (int k = 0; k < N + 1; k++) step(0, 0, 0, 0, 0);
        // R5 R6: gapped stream with garbage operands during idle cycles
        req = "R5 R6";
        for (int k = 0; k < 1500; k++) begin
            next_rng();
            step(rng[0] & rng[3], rng[15:8], rng[7:0], rng[11:4], 0);
        end
        for (int k = 0; k < N + 1; k++) begin
            next_rng();
            step(0, rng[15:8], rng[7:0], rng[11:4], 0);
        end
        // R7: reset while the array is full, then restart
        req = "R7";
        for (int k = 0; k < N + 2; k++) step(1, 8'(k + 10), 8'(k + 20), 8'(k), 0);
        step(1, 8'd99, 8'd99, 8'd99, 1);
        for (int k = 0; k < N + 1; k++) step(0, 0, 0, 0, 0);
        for (int k = 0; k < 3 * N; k++) step(1, 8'(k * 17), 8'(200 - k), 8'(k), 0);
        for (int k = 0; k < N + 2; k++) step(0, 0, 0, 0, 0);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog %s run did not finish", req);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule